// File: doc/BRIEF.md
# Three-Phase Complementary PWM Generator with Dead Time

This block drives the six gate signals of a three-phase inverter bridge. A down-counting carrier timer sets the PWM frame. Each time the carrier underflows, three one-shot phase timers start. Each phase timer's high-side pulse length comes from a width value, and there are two width values per phase that are used on alternate underflows. When a phase's one-shot pulse ends, an 8-bit dead-time counter must run out before the complementary low-side output turns on. The dead-time counter can be clocked at the base rate, half rate or quarter rate.

The output polarity is captured while the block is disabled. It is captured inverted, which is the one-time inversion applied before the outputs settle, and it stays frozen while the block runs. Each phase can be held in its fixed (idle) state. An interrupt request pulse can be thinned to every second or every fourth carrier underflow, and it can be aligned to even-numbered or odd-numbered underflows. Configuration arrives as plain input levels. Dropping the global enable clears every counter and parks all outputs at their inactive levels.

Top module: `tpwm_deadtime`

## Requirements
- R1: While `en` is high the carrier underflows in the first enabled cycle and then once every `period`+1 cycles, reloading from `period`; any value 0000h to FFFFh is accepted.
- R2: The high-side logical output of a phase is active for exactly as many cycles as the width value selected at the underflow that started it.
- R3: Underflows are numbered from 0 after enable. An even-numbered underflow starts the one-shots with `width_a`, and an odd-numbered one starts them with `width_b`. Phase i uses bits [16i+15:16i], with U=0, V=1 and W=2.
- R4: A width value is sampled only at an underflow, so changing it during a pulse does not alter that pulse; the change is used from the next underflow of matching parity onward.
- R5: After a high-side output turns off, both outputs of that phase stay inactive for exactly (`dead`+1)×D+1 cycles before the low side turns on. D is set by `dt_sel`: 00→1, 01→2, 10→4, 11→4.
- R6: A high-side output and its complement are never active in the same cycle.
- R7: `irq` is a one-cycle pulse one cycle after a qualifying underflow. For underflow number n: with `irq_every4`=0 it fires when n mod 2 equals `irq_odd`; with `irq_every4`=1 it fires when n mod 4 equals `irq_odd`.
- R8: Pin level = logical activity XOR the inverse of the `pol_buf` bit. Bits [2:0] of `pol_buf` belong to `drv_hi` U,V,W and bits [5:3] to `drv_lo` U,V,W. The value is captured while `en` is low and ignored while `en` is high.
- R9: While `phase_run[i]` is 0, both outputs of phase i stay at their inactive level whatever the timers do.
- R10: With `rst` high, or within two clock edges after `en` goes low, all pins are at their inactive levels and `irq` is 0. Re-enabling restarts the underflow numbering at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock f |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Global run enable |
| period | input | 16 | Carrier reload value |
| width_a | input | 48 | Per-phase widths for even underflows |
| width_b | input | 48 | Per-phase widths for odd underflows |
| dead | input | 8 | Dead-time count |
| dt_sel | input | 2 | Dead-time clock divider select |
| pol_buf | input | 6 | Polarity setting, loaded inverted |
| phase_run | input | 3 | Per-phase release from fixed state |
| irq_every4 | input | 1 | Interrupt thinning: 0 every 2nd, 1 every 4th |
| irq_odd | input | 1 | Interrupt alignment to odd underflows |
| drv_hi | output | 3 | High-side gate pins U,V,W |
| drv_lo | output | 3 | Low-side gate pins U,V,W |
| irq | output | 1 | Interrupt request pulse |

## Verification
The interrupt flag is registered once, so it appears one cycle after the underflow. Counting the first enabled cycle as sample 0, the bench expects it at sample 10n for a reload of 9. The gate pins pass through two registers after the one-shot counter, which shifts every edge by the same amount. For that reason the bench measures pulse widths and dead gaps as run lengths of negedge samples between pin transitions rather than as absolute cycle numbers. Polarity and disable checks wait three edges after their stimulus so that both the capture register and the pin register have settled.

// File: rtl/tpwm_pkg.sv
package tpwm_pkg;
  typedef enum logic [1:0] {
    DT_DIV1 = 2'b00,
    DT_DIV2 = 2'b01,
    DT_DIV4 = 2'b10,
    DT_DIV4B = 2'b11
  } dt_div_e;

  // last prescaler value before a dead-time tick (divider minus one)
  function automatic logic [1:0] dt_last(input logic [1:0] sel);
    case (dt_div_e'(sel))
      DT_DIV1: dt_last = 2'd0;
      DT_DIV2: dt_last = 2'd1;
      default: dt_last = 2'd3;
    endcase
  endfunction
endpackage

// File: rtl/tpwm_carrier.sv
module tpwm_carrier #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [CW-1:0] period,
  output logic          uf,
  output logic [1:0]    uf_idx
);
  logic [CW-1:0] cnt;

  assign uf = en && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt    <= '0;
      uf_idx <= '0;
    end else if (cnt == '0) begin
      cnt    <= period;
      uf_idx <= uf_idx + 2'd1;
    end else begin
      cnt <= cnt - 1'b1;
    end
  end

  assert_carrier_dec_R1: assert property (@(posedge clk) disable iff (rst)
    (en && cnt != '0) |=> (!en || cnt == $past(cnt) - 1'b1));

  assert_carrier_reload_R1: assert property (@(posedge clk) disable iff (rst)
    uf |=> (!en || cnt == $past(period)));
endmodule

// File: rtl/tpwm_phase.sv
module tpwm_phase #(
  parameter int CW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          run,
  input  logic          uf,
  input  logic [CW-1:0] width,
  input  logic [DW-1:0] dead,
  input  logic [1:0]    div_last,
  output logic          hi_log,
  output logic          lo_log
);
  logic [CW-1:0] os_cnt;
  logic [DW-1:0] dt_cnt;
  logic [1:0]    pre;
  logic          p, p_q, dt_busy, fall;

  assign p    = (os_cnt != '0);
  assign fall = p_q && !p;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      os_cnt  <= '0;
      p_q     <= 1'b0;
      dt_busy <= 1'b0;
      dt_cnt  <= '0;
      pre     <= '0;
      hi_log  <= 1'b0;
      lo_log  <= 1'b0;
    end else begin
      if (uf)
        os_cnt <= width;
      else if (p)
        os_cnt <= os_cnt - 1'b1;
      p_q <= p;

      if (p) begin
        dt_busy <= 1'b0;
      end else if (fall) begin
        dt_busy <= 1'b1;
        dt_cnt  <= dead;
        pre     <= '0;
      end else if (dt_busy) begin
        if (pre == div_last) begin
          pre <= '0;
          if (dt_cnt == '0)
            dt_busy <= 1'b0;
          else
            dt_cnt <= dt_cnt - 1'b1;
        end else begin
          pre <= pre + 2'd1;
        end
      end

      hi_log <= run && p;
      lo_log <= run && !p && !p_q && !dt_busy;
    end
  end

  assert_no_overlap_R6: assert property (@(posedge clk) disable iff (rst)
    !(hi_log && lo_log));

  assert_dead_hold_R5: assert property (@(posedge clk) disable iff (rst)
    dt_busy |=> !lo_log);

  assert_fixed_idle_R9: assert property (@(posedge clk) disable iff (rst)
    !run |=> (!hi_log && !lo_log));
endmodule

// File: rtl/tpwm_irq.sv
module tpwm_irq (
  input  logic       clk,
  input  logic       rst,
  input  logic       uf,
  input  logic [1:0] uf_idx,
  input  logic       every4,
  input  logic       odd,
  output logic       irq
);
  logic hit;

  assign hit = every4 ? (uf_idx == {1'b0, odd}) : (uf_idx[0] == odd);

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= uf && hit;
  end

  assert_irq_single_R7: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq);
endmodule

// File: rtl/tpwm_deadtime.sv
module tpwm_deadtime
  import tpwm_pkg::*;
#(
  parameter int CW = 16,
  parameter int DW = 8,
  parameter int PH = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  logic [CW-1:0]   period,
  input  logic [PH*CW-1:0] width_a,
  input  logic [PH*CW-1:0] width_b,
  input  logic [DW-1:0]   dead,
  input  logic [1:0]      dt_sel,
  input  logic [2*PH-1:0] pol_buf,
  input  logic [PH-1:0]   phase_run,
  input  logic            irq_every4,
  input  logic            irq_odd,
  output logic [PH-1:0]   drv_hi,
  output logic [PH-1:0]   drv_lo,
  output logic            irq
);
  logic          uf;
  logic [1:0]    uf_idx;
  logic [1:0]    div_last;
  logic [PH-1:0] hi_log, lo_log;
  logic [2*PH-1:0] pol_q;

  assign div_last = dt_last(dt_sel);

  tpwm_carrier #(.CW(CW)) u_carrier (
    .clk(clk), .rst(rst), .en(en), .period(period),
    .uf(uf), .uf_idx(uf_idx)
  );

  for (genvar g = 0; g < PH; g++) begin : g_phase
    logic [CW-1:0] wsel;
    assign wsel = uf_idx[0] ? width_b[g*CW +: CW] : width_a[g*CW +: CW];
    tpwm_phase #(.CW(CW), .DW(DW)) u_phase (
      .clk(clk), .rst(rst), .en(en), .run(phase_run[g]), .uf(uf),
      .width(wsel), .dead(dead), .div_last(div_last),
      .hi_log(hi_log[g]), .lo_log(lo_log[g])
    );
  end

  tpwm_irq u_irq (
    .clk(clk), .rst(rst), .uf(uf), .uf_idx(uf_idx),
    .every4(irq_every4), .odd(irq_odd), .irq(irq)
  );

  // polarity: captured inverted while idle, frozen while running
  always_ff @(posedge clk) begin
    if (rst || !en) pol_q <= ~pol_buf;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      drv_hi <= ~pol_buf[PH-1:0];
      drv_lo <= ~pol_buf[2*PH-1:PH];
    end else begin
      drv_hi <= hi_log ^ pol_q[PH-1:0];
      drv_lo <= lo_log ^ pol_q[2*PH-1:PH];
    end
  end

  assert_off_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    !en |=> !irq);
endmodule

// File: tb/tpwm_deadtime_bench.sv
module tpwm_deadtime_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 5;
  localparam int V_PER [NV] = '{40, 60, 80, 50, 100};
  localparam int V_W   [NV] = '{10, 20, 5, 1, 30};
  localparam int V_D   [NV] = '{3, 2, 4, 0, 7};
  localparam int V_SEL [NV] = '{0, 1, 2, 0, 3};
  localparam int V_EXPW[NV] = '{10, 20, 5, 1, 30};
  localparam int V_EXPG[NV] = '{5, 7, 21, 2, 33};

  logic clk = 0, rst = 1, en = 0;
  logic [15:0] period = 16'd40;
  logic [47:0] width_a = '0, width_b = '0;
  logic [7:0]  dead = '0;
  logic [1:0]  dt_sel = '0;
  logic [5:0]  pol_buf = 6'b111111;
  logic [2:0]  phase_run = 3'b111;
  logic        irq_every4 = 0, irq_odd = 0;
  logic [2:0]  drv_hi, drv_lo;
  logic        irq;

  int checks = 0, failures = 0;

  tpwm_deadtime u_tpwm_deadtime (
    .clk(clk), .rst(rst), .en(en), .period(period),
    .width_a(width_a), .width_b(width_b), .dead(dead), .dt_sel(dt_sel),
    .pol_buf(pol_buf), .phase_run(phase_run), .irq_every4(irq_every4),
    .irq_odd(irq_odd), .drv_hi(drv_hi), .drv_lo(drv_lo), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // measures one U-phase pulse and the following dead gap (high-active pins)
  task automatic measure(output int w, output int g, output int ovl);
    int guard = 0;
    w = 0; g = 0; ovl = 0;
    while (!drv_hi[0] && guard < 3000) begin guard++; @(negedge clk); end
    while (drv_hi[0] && guard < 3000) begin
      w++; guard++;
      if (drv_lo[0]) ovl++;
      @(negedge clk);
    end
    while (!drv_hi[0] && !drv_lo[0] && guard < 3000) begin g++; guard++; @(negedge clk); end
  endtask

  task automatic irq_run(input bit e4, input bit od, input int exp_cnt, input string req);
    int cnt = 0, bad = 0;
    en = 0; period = 16'd9; irq_every4 = e4; irq_odd = od;
    idle(3);
    en = 1;
    for (int j = 0; j < 80; j++) begin
      bit want;
      @(negedge clk);
      want = (j % 10 == 0) && (e4 ? ((j/10) % 4 == int'(od)) : ((j/10) % 2 == int'(od)));
      if (irq) cnt++;
      if (irq != want) bad++;
    end
    chk(bad == 0, req, bad, 0);
    chk(cnt == exp_cnt, req, cnt, exp_cnt);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int w, g, o;
    // reset state, R10 / R8
    pol_buf = 6'b111111;
    idle(3);
    chk(drv_hi == 3'b000 && drv_lo == 3'b000, "R10 reset pins", {drv_hi, drv_lo}, 0);
    chk(irq == 0, "R10 reset irq", irq, 0);
    rst = 0;
    pol_buf = 6'b000000;
    idle(3);
    chk(drv_hi == 3'b111 && drv_lo == 3'b111, "R8 inverted capture", {drv_hi, drv_lo}, 63);
    pol_buf = 6'b000110;
    idle(3);
    chk(drv_hi == 3'b001 && drv_lo == 3'b111, "R8 bit mapping", {drv_hi, drv_lo}, 15);

    // vector table: R2 width, R5 dead gap, R6 no overlap
    pol_buf = 6'b111111; phase_run = 3'b111;
    for (int v = 0; v < NV; v++) begin
      en = 0;
      period = 16'(V_PER[v]);
      width_a = {3{16'(V_W[v])}}; width_b = width_a;
      dead = 8'(V_D[v]); dt_sel = 2'(V_SEL[v]);
      idle(3);
      en = 1;
      measure(w, g, o);
      chk(w == V_EXPW[v], "R2 pulse width", w, V_EXPW[v]);
      chk(g == V_EXPG[v], "R5 dead gap", g, V_EXPG[v]);
      chk(o == 0 && drv_lo[0], "R6 overlap/low-side on", o, 0);
    end

    // R3 alternating widths
    en = 0; period = 16'd60; dead = 8'd1; dt_sel = 2'b00;
    width_a = {3{16'd10}}; width_b = {3{16'd25}};
    idle(3); en = 1;
    measure(w, g, o); chk(w == 10, "R3 even uses width_a", w, 10);
    measure(w, g, o); chk(w == 25, "R3 odd uses width_b", w, 25);
    measure(w, g, o); chk(w == 10, "R3 even again", w, 10);

    // R4 double buffering
    en = 0; width_a = {3{16'd12}}; width_b = {3{16'd12}};
    idle(3); en = 1;
    begin
      int guard = 0;
      while (!drv_hi[0] && guard < 3000) begin guard++; @(negedge clk); end
      w = 0;
      while (drv_hi[0] && guard < 3000) begin
        w++; guard++;
        if (w == 3) width_a = {3{16'd30}};
        @(negedge clk);
      end
    end
    chk(w == 12, "R4 pulse in flight keeps width", w, 12);
    measure(w, g, o); chk(w == 12, "R4 odd pulse unaffected", w, 12);
    measure(w, g, o); chk(w == 30, "R4 new width at next even", w, 30);

    // R9 fixation of V
    en = 0; phase_run = 3'b101; width_a = {3{16'd10}}; width_b = width_a;
    period = 16'd40;
    idle(3); en = 1;
    begin
      int vact = 0, uact = 0;
      for (int i = 0; i < 100; i++) begin
        @(negedge clk);
        if (drv_hi[1] || drv_lo[1]) vact++;
        if (drv_hi[0]) uact++;
      end
      chk(vact == 0, "R9 fixed phase idle", vact, 0);
      chk(uact == 30, "R9 released phase runs", uact, 30);
    end

    // R8 polarity frozen while running
    phase_run = 3'b000; en = 0; pol_buf = 6'b111111;
    idle(3); en = 1; idle(5);
    pol_buf = 6'b000000; idle(5);
    chk(drv_hi == 3'b000 && drv_lo == 3'b000, "R8 frozen while enabled", {drv_hi, drv_lo}, 0);

    // R10 disable parks pins
    en = 0; idle(3);
    chk(drv_hi == 3'b111 && drv_lo == 3'b111, "R10 disabled inactive", {drv_hi, drv_lo}, 63);
    pol_buf = 6'b111111; phase_run = 3'b111; period = 16'd40;
    idle(3); en = 1; idle(15);
    en = 0; idle(2);
    chk(drv_hi == 0 && drv_lo == 0 && irq == 0, "R10 disable mid pulse", {drv_hi, drv_lo}, 0);

    // R7 / R1 interrupt thinning and alignment
    irq_run(0, 0, 4, "R7 every2 even (R1 spacing)");
    irq_run(0, 1, 4, "R7 every2 odd");
    irq_run(1, 0, 2, "R7 every4 even");
    irq_run(1, 1, 2, "R7 every4 odd");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule